// File: doc/BRIEF.md
# DMA Request and Slave Select for a Legacy Host Port

This block sits at the edge of a host port that talks to a legacy expansion bus with a third-party DMA controller. Inside the chip, a receive path and a transmit path each raise a level request when they want service. The block merges those requests under per-direction enables and a global DMA enable, and drives one request line towards the external DMA controller. The line's active level is set by a polarity control. The request drops while the controller answers with its acknowledge.

The same block works out whether the current bus cycle belongs to this port. The bus can run with separate read and write strobes or with a single data strobe, and a mode input picks which decode applies. An address-enable input sets the kind of cycle. When it is high, only DMA cycles are answered, and only if DMA is enabled. When it is low, the port answers a strobed cycle whose address the neighbouring decoder has recognised.

The bus-side acknowledge, strobes and address-enable are asynchronous. They pass through a two-stage synchronizer before any decode. The select results and a select-acknowledge back to the host are registered.

Top module: `dma_req_select`

## Requirements
- R1: During and right after reset, `dma_req_pin` sits at its inactive level (the inverse of `req_pol`), `dma_sel` and `io_sel` are 0 and `sel_ack_n` is 1.
- R2: With `dma_en`=1 and no acknowledge, a receive source (`rx_req_src`=1 with `rx_req_en`=1) or a transmit source (`tx_req_src`=1 with `tx_req_en`=1) drives `dma_req_pin` to its active level one clock after the inputs are presented.
- R3: A source whose enable is 0 does not raise the request.
- R4: With `dma_en`=0 the request is inactive whatever the sources and enables are.
- R5: While the synchronized acknowledge is active (`dma_ack_n`=0), the request is held inactive.
- R6: `req_pol`=1 makes the request active high, and `req_pol`=0 makes it active low. The polarity is registered together with the request.
- R7: With `strobe_mode`=0 (separate strobes), `dma_sel` is 1 when the acknowledge is active, `rd_n`=0 or `wr_n`=0, `addr_en`=1 and `dma_en`=1. `ds_n` has no effect in this mode.
- R8: With `strobe_mode`=1 (single strobe), the strobe term is `ds_n`=0 alone, and `rd_n`/`wr_n` have no effect.
- R9: With `addr_en`=1 and `dma_en`=0, a DMA cycle is ignored: `dma_sel`=0, `io_sel`=0 and `sel_ack_n`=1.
- R10: With `addr_en`=0, `io_sel` is 1 when `addr_hit`=1 and the mode's strobe term is active, and `dma_sel` stays 0 even with the acknowledge active.
- R11: `sel_ack_n` is 0 exactly while `dma_sel` or `io_sel` is 1, and at most one of those two is 1.
- R12: A change on `dma_ack_n`, `rd_n`, `wr_n`, `ds_n` or `addr_en` reaches the select outputs three clocks after it is applied: two synchronizer stages, then the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_req_src | input | 1 | Receive path wants DMA service |
| tx_req_src | input | 1 | Transmit path wants DMA service |
| rx_req_en | input | 1 | Enable for the receive request |
| tx_req_en | input | 1 | Enable for the transmit request |
| dma_en | input | 1 | Global DMA enable |
| req_pol | input | 1 | Request line polarity, 1 = active high |
| strobe_mode | input | 1 | 0 = separate read and write strobes, 1 = single data strobe |
| dma_ack_n | input | 1 | DMA acknowledge from the bus, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| ds_n | input | 1 | Data strobe, active low, asynchronous |
| addr_en | input | 1 | Address enable, high = DMA cycles only, asynchronous |
| addr_hit | input | 1 | Port address recognised, synchronous to clk |
| dma_req_pin | output | 1 | Request line to the external DMA controller |
| dma_sel | output | 1 | Port selected as a DMA device |
| io_sel | output | 1 | Port selected by address decode |
| sel_ack_n | output | 1 | Select acknowledge to the host, active low |

## Verification
The assertions assume that `req_pol`, `dma_en`, the enables and `addr_hit` are synchronous to `clk`. Only the bus-side acknowledge, strobes and address-enable may change at any time. The request checks compare the line with the polarity sampled one clock earlier, so they remain valid even if the polarity changes at run time. The stimulus changes inputs only on falling clock edges. It holds each pattern for four clocks, which is longer than the three-clock path through the synchronizer, before the scoreboard compares the outputs. The synchronizer latency itself is measured in a dedicated sequence that samples at exactly two and three clocks.

// File: rtl/dma_sel_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the DMA request and select block.
// Assumes: the synchronized bus bundle is packed in the order given by the
// struct so the synchronizer can treat it as a plain vector.
package dma_sel_pkg;

    // Strobe decode variants of the host bus
    typedef enum logic {
        STB_SPLIT  = 1'b0,   // separate read and write strobes
        STB_SINGLE = 1'b1    // one data strobe
    } strobe_mode_e;

    // Bus-side controls, all converted to active high before synchronizing
    typedef struct packed {
        logic ack;
        logic rd;
        logic wr;
        logic ds;
        logic aen;
    } bus_ctl_t;

    localparam int BUS_CTL_W = $bits(bus_ctl_t);

endpackage

// File: rtl/dma_in_sync.sv
`timescale 1ns/1ps
// Module: multi-stage synchronizer for a vector of asynchronous levels.
// Assumes: each bit is an independent level; no bus coherence is required.
// Reset loads the idle (0) value into every stage.
module dma_in_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage samples the asynchronous input
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= '0;
                    else        stage_q[g] <= d;
                end
            end else begin : g_next
                // Later stages resolve metastability
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= '0;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/dma_req_gate.sv
`timescale 1ns/1ps
// Module: combines per-direction DMA request sources into one bus request.
// Assumes: sources, enables, dma_en and pol are synchronous to clk;
// ack_act is already synchronized. The pin level register takes the
// polarity at the same edge as the request so they never disagree.
module dma_req_gate #(
    parameter int NUM_SRC = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic               dma_en,
    input  logic               ack_act,
    input  logic               pol,
    output logic               req_pin
);

    logic [NUM_SRC-1:0] masked;
    logic               want;
    logic               pin_q;

    // Per-direction masking of the sources
    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            masked[i] = src[i] & src_en[i];
        end
    end

    // Global enable and acknowledge clear
    assign want = dma_en & (|masked) & ~ack_act;

    // Register the pin level in the chosen polarity
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= ~pol;
        else        pin_q <= pol ? want : ~want;
    end

    assign req_pin = pin_q;

endmodule

// File: rtl/dma_sel_decode.sv
`timescale 1ns/1ps
// Module: decides whether the current bus cycle selects this port, either
// as a DMA device or through its own address, and drives select acknowledge.
// Assumes: bus controls arrive synchronized and active high; addr_hit and
// dma_en are synchronous to clk.
module dma_sel_decode
    import dma_sel_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  strobe_mode_e mode,
    input  bus_ctl_t     bus,
    input  logic         dma_en,
    input  logic         addr_hit,
    output logic         dma_sel,
    output logic         io_sel,
    output logic         sel_ack_n
);

    logic strobe;
    logic dma_hit;
    logic io_hit;
    logic dma_q;
    logic io_q;
    logic sak_q;

    // Strobe term according to bus mode
    always_comb begin
        unique case (mode)
            STB_SINGLE: strobe = bus.ds;
            default:    strobe = bus.rd | bus.wr;
        endcase
    end

    // Cycle qualification by address enable
    always_comb begin
        dma_hit = 1'b0;
        io_hit  = 1'b0;
        if (bus.aen) dma_hit = dma_en & bus.ack & strobe;
        else         io_hit  = addr_hit & strobe;
    end

    // Register the select results and the acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_q <= 1'b0;
            io_q  <= 1'b0;
            sak_q <= 1'b1;
        end else begin
            dma_q <= dma_hit;
            io_q  <= io_hit;
            sak_q <= ~(dma_hit | io_hit);
        end
    end

    assign dma_sel   = dma_q;
    assign io_sel    = io_q;
    assign sel_ack_n = sak_q;

endmodule

// File: rtl/dma_req_select.sv
`timescale 1ns/1ps
// Module: top level of the DMA request and slave select logic for a legacy
// host port. Synchronizes bus controls, gates the DMA request and decodes
// port selection.
// Assumes: internal-side inputs are synchronous to clk; bus-side controls
// are asynchronous and need SYNC_STAGES flops.
module dma_req_select #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_req_src,
    input  logic tx_req_src,
    input  logic rx_req_en,
    input  logic tx_req_en,
    input  logic dma_en,
    input  logic req_pol,
    input  logic strobe_mode,
    input  logic dma_ack_n,
    input  logic rd_n,
    input  logic wr_n,
    input  logic ds_n,
    input  logic addr_en,
    input  logic addr_hit,
    output logic dma_req_pin,
    output logic dma_sel,
    output logic io_sel,
    output logic sel_ack_n
);
    import dma_sel_pkg::*;

    localparam int NUM_DIR = 2;

    bus_ctl_t           bus_raw;
    bus_ctl_t           bus_sync;
    logic [BUS_CTL_W-1:0] bus_sync_vec;
    logic [NUM_DIR-1:0] dir_src;
    logic [NUM_DIR-1:0] dir_en;
    logic               ack_act;

    // Convert bus controls to active high before synchronizing
    always_comb begin
        bus_raw.ack = ~dma_ack_n;
        bus_raw.rd  = ~rd_n;
        bus_raw.wr  = ~wr_n;
        bus_raw.ds  = ~ds_n;
        bus_raw.aen = addr_en;
    end

    dma_in_sync #(
        .WIDTH  (BUS_CTL_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (bus_raw),
        .q     (bus_sync_vec)
    );

    assign bus_sync = bus_ctl_t'(bus_sync_vec);
    assign ack_act  = bus_sync.ack;
    assign dir_src  = {tx_req_src, rx_req_src};
    assign dir_en   = {tx_req_en, rx_req_en};

    dma_req_gate #(
        .NUM_SRC (NUM_DIR)
    ) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .src     (dir_src),
        .src_en  (dir_en),
        .dma_en  (dma_en),
        .ack_act (ack_act),
        .pol     (req_pol),
        .req_pin (dma_req_pin)
    );

    dma_sel_decode u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (strobe_mode_e'(strobe_mode)),
        .bus       (bus_sync),
        .dma_en    (dma_en),
        .addr_hit  (addr_hit),
        .dma_sel   (dma_sel),
        .io_sel    (io_sel),
        .sel_ack_n (sel_ack_n)
    );

endmodule

// File: rtl/dma_req_select_chk.sv
`timescale 1ns/1ps
// Module: assertion checker for dma_req_select, attached by bind.
// Assumes: req_pol, dma_en, enables and addr_hit are synchronous to clk.
module dma_req_select_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_req_src,
    input logic tx_req_src,
    input logic rx_req_en,
    input logic tx_req_en,
    input logic dma_en,
    input logic req_pol,
    input logic addr_hit,
    input logic ack_act,
    input logic dma_req_pin,
    input logic dma_sel,
    input logic io_sel,
    input logic sel_ack_n
);

    // Enabled receive source raises the line to the active level
    assert_req_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_req_src && rx_req_en && dma_en && !ack_act)
        |=> (dma_req_pin == $past(req_pol)));

    // Masked sources leave the line inactive
    assert_mask_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((!rx_req_src || !rx_req_en) && (!tx_req_src || !tx_req_en))
        |=> (dma_req_pin == !$past(req_pol)));

    // Global disable leaves the line inactive
    assert_global_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |=> (dma_req_pin == !$past(req_pol)));

    // Acknowledge clears the request
    assert_ack_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_act |=> (dma_req_pin == !$past(req_pol)));

    // DMA select only follows a cycle with DMA enabled
    assert_dma_needs_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dma_sel |-> $past(dma_en));

    // Address select only follows a recognised address
    assert_io_needs_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        io_sel |-> $past(addr_hit));

    // Select acknowledge mirrors the two selects, which exclude each other
    assert_sel_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_ack_n == !(dma_sel || io_sel)) && $onehot0({dma_sel, io_sel}));

    // Unused-free: tx inputs participate in the mask check above
endmodule

bind dma_req_select dma_req_select_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_req_src  (rx_req_src),
    .tx_req_src  (tx_req_src),
    .rx_req_en   (rx_req_en),
    .tx_req_en   (tx_req_en),
    .dma_en      (dma_en),
    .req_pol     (req_pol),
    .addr_hit    (addr_hit),
    .ack_act     (ack_act),
    .dma_req_pin (dma_req_pin),
    .dma_sel     (dma_sel),
    .io_sel      (io_sel),
    .sel_ack_n   (sel_ack_n)
);

// File: tb/tb_dma_req_select.sv
`timescale 1ns/1ps
// Bench: scoreboard driven. A driver task applies a pattern, lets it settle
// and queues the expected outputs; a monitor pops and compares them.
module tb_dma_req_select;

    typedef struct {
        logic  pin;
        logic  dsel;
        logic  isel;
        logic  sak;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n;
    logic rx_req_src, tx_req_src, rx_req_en, tx_req_en;
    logic dma_en, req_pol, strobe_mode;
    logic dma_ack_n, rd_n, wr_n, ds_n, addr_en, addr_hit;
    logic dma_req_pin, dma_sel, io_sel, sel_ack_n;

    int   checks   = 0;
    int   failures = 0;
    bit   finished = 1'b0;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    dma_req_select dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_req_src  (rx_req_src),
        .tx_req_src  (tx_req_src),
        .rx_req_en   (rx_req_en),
        .tx_req_en   (tx_req_en),
        .dma_en      (dma_en),
        .req_pol     (req_pol),
        .strobe_mode (strobe_mode),
        .dma_ack_n   (dma_ack_n),
        .rd_n        (rd_n),
        .wr_n        (wr_n),
        .ds_n        (ds_n),
        .addr_en     (addr_en),
        .addr_hit    (addr_hit),
        .dma_req_pin (dma_req_pin),
        .dma_sel     (dma_sel),
        .io_sel      (io_sel),
        .sel_ack_n   (sel_ack_n)
    );

    task automatic check1(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Driver: apply a pattern, settle, push the expected outputs
    task automatic apply(input logic rxs, rxe, txs, txe, den, pol, mode,
                         input logic ackn, rdn, wrn, dsn, aen, hit,
                         input string tag);
        exp_t e;
        logic req, stb;
        @(negedge clk);
        rx_req_src = rxs; rx_req_en = rxe; tx_req_src = txs; tx_req_en = txe;
        dma_en = den; req_pol = pol; strobe_mode = mode;
        dma_ack_n = ackn; rd_n = rdn; wr_n = wrn; ds_n = dsn;
        addr_en = aen; addr_hit = hit;
        repeat (4) @(posedge clk);
        @(negedge clk);
        req    = den & ((rxs & rxe) | (txs & txe)) & ackn;
        stb    = mode ? ~dsn : (~rdn | ~wrn);
        e.pin  = pol ? req : ~req;
        e.dsel = aen & den & ~ackn & stb;
        e.isel = ~aen & hit & stb;
        e.sak  = ~(e.dsel | e.isel);
        e.tag  = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compare queued expectations with the outputs
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check1({e.tag, " req_pin"},     dma_req_pin, e.pin);
                check1({e.tag, " dma_sel"},     dma_sel,     e.dsel);
                check1({e.tag, " io_sel"},      io_sel,      e.isel);
                check1({e.tag, " sel_ack R11"}, sel_ack_n,   e.sak);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        rx_req_src = 0; tx_req_src = 0; rx_req_en = 0; tx_req_en = 0;
        dma_en = 0; req_pol = 1; strobe_mode = 0;
        dma_ack_n = 1; rd_n = 1; wr_n = 1; ds_n = 1; addr_en = 0; addr_hit = 0;
        rx_req_src = 1; rx_req_en = 1; dma_en = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check1("R1 pin in reset", dma_req_pin, 1'b0);
        rst_n = 1'b1;
        rx_req_src = 0; rx_req_en = 0; dma_en = 0;
        @(posedge clk);
        @(negedge clk);
        check1("R1 pin after reset", dma_req_pin, 1'b0);
        check1("R1 dma_sel",         dma_sel,     1'b0);
        check1("R1 io_sel",          io_sel,      1'b0);
        check1("R1 sel_ack_n",       sel_ack_n,   1'b1);

        //     rxs rxe txs txe den pol mod ack rd wr ds aen hit
        apply(1, 1, 0, 0, 1, 1, 0, 1, 1, 1, 1, 0, 0, "R2 rx request");
        apply(0, 0, 1, 1, 1, 1, 0, 1, 1, 1, 1, 0, 0, "R2 tx request");
        apply(1, 0, 0, 1, 1, 1, 0, 1, 1, 1, 1, 0, 0, "R3 rx masked");
        apply(0, 1, 1, 0, 1, 1, 0, 1, 1, 1, 1, 0, 0, "R3 tx masked");
        apply(1, 1, 1, 1, 0, 1, 0, 1, 1, 1, 1, 0, 0, "R4 global off");
        apply(1, 1, 0, 0, 1, 0, 0, 1, 1, 1, 1, 0, 0, "R6 active low set");
        apply(0, 1, 0, 1, 1, 0, 0, 1, 1, 1, 1, 0, 0, "R6 active low idle");
        apply(1, 1, 1, 1, 1, 1, 0, 0, 1, 1, 1, 1, 0, "R5 ack clears");
        apply(1, 1, 0, 0, 1, 1, 0, 0, 0, 1, 1, 1, 0, "R7 read strobe");
        apply(0, 0, 1, 1, 1, 1, 0, 0, 1, 0, 1, 1, 0, "R7 write strobe");
        apply(0, 0, 0, 0, 1, 1, 0, 0, 1, 1, 0, 1, 0, "R7 ds ignored");
        apply(0, 0, 0, 0, 1, 1, 1, 0, 0, 0, 1, 1, 0, "R8 rd wr ignored");
        apply(0, 0, 0, 0, 1, 0, 1, 0, 1, 1, 0, 1, 0, "R8 data strobe");
        apply(1, 1, 0, 0, 0, 1, 0, 0, 0, 1, 1, 1, 1, "R9 dma disabled");
        apply(0, 0, 0, 0, 1, 1, 0, 0, 0, 1, 1, 0, 1, "R10 address hit");
        apply(0, 0, 0, 0, 1, 1, 0, 0, 0, 1, 1, 0, 0, "R10 no hit");
        apply(0, 0, 0, 0, 0, 1, 1, 1, 1, 1, 0, 0, 1, "R10 single strobe hit");
        apply(0, 0, 0, 0, 1, 1, 0, 1, 1, 1, 1, 1, 0, "R12 idle");
        repeat (2) @(negedge clk);

        // R12: DMA cycle reaches dma_sel exactly three clocks after it starts
        dma_ack_n = 1'b0; rd_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check1("R12 dma_sel at 2 clocks", dma_sel, 1'b0);
        @(posedge clk);
        @(negedge clk);
        check1("R12 dma_sel at 3 clocks", dma_sel, 1'b1);
        // R5: request line drops three clocks after acknowledge
        dma_ack_n = 1'b1; rd_n = 1'b1; rx_req_src = 1'b1; rx_req_en = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check1("R5 request before ack", dma_req_pin, 1'b1);
        dma_ack_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check1("R5 request at 2 clocks", dma_req_pin, 1'b1);
        @(posedge clk);
        @(negedge clk);
        check1("R5 request at 3 clocks", dma_req_pin, 1'b0);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule